// File: doc/BRIEF.md
# Per-Channel Cell Reassembly Engine

This block sits behind a cell receiver and turns a stream of 48-byte payload cells back into whole messages. Every cell arrives with a virtual channel number, an end-of-message marker and, on the closing cell, the CRC verdict that an upstream checker has accumulated. A channel map, loaded through a small write port, sends each channel to one of several receive endpoints. Reassembly context is held for each channel on its own, so cells of messages on different channels may be interleaved freely.

A multi-cell message claims one buffer, taken from the head of its endpoint's free queue when the first cell arrives. Each cell is then written into that buffer at the next 48-byte offset. When the last cell arrives, a receive descriptor is pushed that names the buffer, the stored length and an error flag. A message that is a single cell takes no buffer: its payload is carried inline in the descriptor. The buffer store, free queues and receive queues sit outside the block. The block drives pop, write and push strobes one cycle after it samples the cell.

Top module: `cell_reasm`

## Requirements
- R1: A cell whose channel has no valid map entry produces no pop, write or push; the `drop_count` output increases by one in the cycle after the cell.
- R2: The first cell of a multi-cell message on a mapped channel whose endpoint has a non-empty free queue pops that queue. In the same output cycle, it writes the payload at byte offset 0 into the buffer index that was at the queue head.
- R3: Each later cell of that message is written into the same buffer index at an offset 48 bytes past the previous cell, in arrival order.
- R4: The cell that carries the end-of-message marker pushes a descriptor with `rq_inline`=0, the buffer index and the stored byte count. Its `rq_err` is 1 when `cell_crc_ok` is 0 on that cell.
- R5: A cell that starts a message and also carries the end-of-message marker pushes a descriptor with `rq_inline`=1, length 48 and the payload on `out_data`. It issues no pop and no buffer write, and `rq_err` is the inverse of `cell_crc_ok`.
- R6: When the free queue of the destination endpoint is empty on the first cell of a multi-cell message, that cell and every later cell of the message, up to and including the end-of-message cell, produce no output. The next message on the channel is handled normally.
- R7: Reassembly context is kept per channel, so cells of messages on different channels may alternate cell by cell without affecting each other.
- R8: A cell that would end past `BUF_BYTES` is not written. Its message's descriptor carries `rq_err`=1 and a length equal to the bytes actually stored.
- R9: After reset all outputs are 0, every channel is idle and every map entry is invalid.
- R10: A map write takes effect for cells in the cycle after the write. A cell presented in the same cycle as a write to its own channel sees the previous entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| map_we | input | 1 | Channel map write strobe |
| map_vc | input | VC_W | Channel being written |
| map_valid | input | 1 | Entry valid bit to write |
| map_ep | input | EP_W | Destination endpoint to write |
| cell_valid | input | 1 | Cell present this cycle |
| cell_vc | input | VC_W | Channel of the cell |
| cell_eom | input | 1 | Cell closes its message |
| cell_crc_ok | input | 1 | Accumulated CRC verdict, meaningful with `cell_eom` |
| cell_data | input | 384 | Cell payload |
| fq_nonempty | input | NUM_EP | Per-endpoint free queue not empty |
| fq_head | input | NUM_EP*IDX_W | Per-endpoint buffer index at the free queue head |
| fq_pop | output | 1 | Pop the free queue of `out_ep` |
| buf_wr | output | 1 | Write `out_data` into buffer `out_idx` of `out_ep` |
| buf_off | output | OFF_W | Byte offset of the buffer write |
| rq_push | output | 1 | Push a descriptor onto the receive queue of `out_ep` |
| rq_inline | output | 1 | Descriptor holds the payload on `out_data` |
| rq_err | output | 1 | Descriptor error flag |
| rq_len | output | OFF_W | Descriptor message length in bytes |
| out_ep | output | EP_W | Endpoint of the current strobes |
| out_idx | output | IDX_W | Buffer index for write or descriptor |
| out_data | output | 384 | Payload of the cell that caused the strobes |
| drop_count | output | CNT_W | Count of cells dropped for an unmapped channel, wrapping |

## Verification
The assertions rely on `fq_nonempty` and `fq_head` being stable around the sampling edge, and on `BUF_BYTES` being at least two cells. They also treat `cell_crc_ok` as meaningful only on an end-of-message cell, and they expect no cell to be offered while reset is asserted. The bench drives every input at the falling edge. It keeps the reset window free of cells. It advances a free queue head only after the edge that popped it, and it raises a queue's empty condition only between messages. That keeps the free-queue view seen by the design consistent with the bench's own model.

// File: rtl/cr_pkg.sv
// Shared constants and types for the cell reassembly engine.
package cr_pkg;
    localparam int CELL_BYTES = 48;
    localparam int CELL_BITS  = CELL_BYTES * 8;

    // Per-channel message phase.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_SKIP = 2'd2
    } phase_t;
endpackage

// File: rtl/cr_vc_map.sv
// Channel map: one valid bit and endpoint number per channel.
// Assumes: a write and a read of the same entry in one cycle returns the old entry.
module cr_vc_map #(
    parameter int NUM_VC = 16,
    parameter int EP_W   = 2,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [VC_W-1:0] wr_vc,
    input  logic            wr_valid,
    input  logic [EP_W-1:0] wr_ep,
    input  logic [VC_W-1:0] rd_vc,
    output logic            rd_hit,
    output logic [EP_W-1:0] rd_ep
);
    logic            vld_q [NUM_VC];
    logic [EP_W-1:0] ep_q  [NUM_VC];

    // Update the addressed entry; clear all entries on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VC; i++) begin
                vld_q[i] <= 1'b0;
                ep_q[i]  <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_vc] <= wr_valid;
            ep_q[wr_vc]  <= wr_ep;
        end
    end

    // Combinational lookup for the incoming cell.
    always_comb begin
        rd_hit = vld_q[rd_vc];
        rd_ep  = ep_q[rd_vc];
    end
endmodule

// File: rtl/cr_ctx_bank.sv
// Per-channel reassembly context: phase, buffer index, bytes stored, overflow.
// Assumes: at most one channel is updated per cycle.
module cr_ctx_bank
    import cr_pkg::*;
#(
    parameter int NUM_VC = 16,
    parameter int IDX_W  = 8,
    parameter int OFF_W  = 17,
    localparam int VC_W  = $clog2(NUM_VC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VC_W-1:0]  rd_vc,
    output phase_t           rd_phase,
    output logic [IDX_W-1:0] rd_idx,
    output logic [OFF_W-1:0] rd_off,
    output logic             rd_ovf,
    input  logic             wr_en,
    input  logic [VC_W-1:0]  wr_vc,
    input  phase_t           wr_phase,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [OFF_W-1:0] wr_off,
    input  logic             wr_ovf
);
    phase_t           ph_q  [NUM_VC];
    logic [IDX_W-1:0] idx_q [NUM_VC];
    logic [OFF_W-1:0] off_q [NUM_VC];
    logic             ovf_q [NUM_VC];

    // Store the new context of the channel just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_VC; i++) begin
                ph_q[i]  <= PH_IDLE;
                idx_q[i] <= '0;
                off_q[i] <= '0;
                ovf_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            ph_q[wr_vc]  <= wr_phase;
            idx_q[wr_vc] <= wr_idx;
            off_q[wr_vc] <= wr_off;
            ovf_q[wr_vc] <= wr_ovf;
        end
    end

    // Read the context of the incoming cell's channel.
    always_comb begin
        rd_phase = ph_q[rd_vc];
        rd_idx   = idx_q[rd_vc];
        rd_off   = off_q[rd_vc];
        rd_ovf   = ovf_q[rd_vc];
    end
endmodule

// File: rtl/cell_reasm.sv
// Cell reassembly engine top. Maps each cell's channel to an endpoint,
// claims a free buffer on the first cell, appends later cells, posts a
// descriptor on the last cell, and inlines single-cell messages.
// Assumes: one cell per cycle at most; fq_head is valid where fq_nonempty is set;
// BUF_BYTES holds at least two cells. Strobes appear one cycle after the cell.
module cell_reasm
    import cr_pkg::*;
#(
    parameter int NUM_VC    = 16,
    parameter int NUM_EP    = 4,
    parameter int IDX_W     = 8,
    parameter int BUF_BYTES = 65536,
    parameter int CNT_W     = 16,
    localparam int VC_W     = $clog2(NUM_VC),
    localparam int EP_W     = $clog2(NUM_EP),
    localparam int OFF_W    = $clog2(BUF_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    map_we,
    input  logic [VC_W-1:0]         map_vc,
    input  logic                    map_valid,
    input  logic [EP_W-1:0]         map_ep,
    input  logic                    cell_valid,
    input  logic [VC_W-1:0]         cell_vc,
    input  logic                    cell_eom,
    input  logic                    cell_crc_ok,
    input  logic [CELL_BITS-1:0]    cell_data,
    input  logic [NUM_EP-1:0]       fq_nonempty,
    input  logic [NUM_EP*IDX_W-1:0] fq_head,
    output logic                    fq_pop,
    output logic                    buf_wr,
    output logic [OFF_W-1:0]        buf_off,
    output logic                    rq_push,
    output logic                    rq_inline,
    output logic                    rq_err,
    output logic [OFF_W-1:0]        rq_len,
    output logic [EP_W-1:0]         out_ep,
    output logic [IDX_W-1:0]        out_idx,
    output logic [CELL_BITS-1:0]    out_data,
    output logic [CNT_W-1:0]        drop_count
);
    localparam logic [OFF_W:0]   BUF_L  = (OFF_W+1)'(BUF_BYTES);
    localparam logic [OFF_W:0]   CELL_L = (OFF_W+1)'(CELL_BYTES);
    localparam logic [OFF_W-1:0] CELL_O = OFF_W'(CELL_BYTES);

    logic             hit;
    logic [EP_W-1:0]  ep;
    phase_t           ph, n_ph;
    logic [IDX_W-1:0] idx, n_idx, head;
    logic [OFF_W-1:0] off, n_off;
    logic             ovf, n_ovf, ctx_we;
    logic [OFF_W:0]   sum;
    logic             fits;

    logic             d_pop, d_wr, d_push, d_inl, d_err, d_drop;
    logic [IDX_W-1:0] d_idx;
    logic [OFF_W-1:0] d_off, d_len;

    cr_vc_map #(.NUM_VC(NUM_VC), .EP_W(EP_W)) u_map (
        .clk(clk), .rst_n(rst_n),
        .wr_en(map_we), .wr_vc(map_vc), .wr_valid(map_valid), .wr_ep(map_ep),
        .rd_vc(cell_vc), .rd_hit(hit), .rd_ep(ep)
    );

    cr_ctx_bank #(.NUM_VC(NUM_VC), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .rd_vc(cell_vc), .rd_phase(ph), .rd_idx(idx), .rd_off(off), .rd_ovf(ovf),
        .wr_en(ctx_we), .wr_vc(cell_vc), .wr_phase(n_ph), .wr_idx(n_idx),
        .wr_off(n_off), .wr_ovf(n_ovf)
    );

    // Room check for the next cell and the head of the endpoint's free queue.
    always_comb begin
        sum  = {1'b0, off} + CELL_L;
        fits = (sum <= BUF_L);
        head = fq_head[ep*IDX_W +: IDX_W];
    end

    // Decide the strobes and the channel's next context for this cell.
    always_comb begin
        d_pop = 1'b0; d_wr = 1'b0; d_push = 1'b0; d_inl = 1'b0;
        d_err = 1'b0; d_drop = 1'b0;
        d_idx = idx; d_off = off; d_len = '0;
        ctx_we = 1'b0; n_ph = ph; n_idx = idx; n_off = off; n_ovf = ovf;
        if (cell_valid) begin
            if (!hit) begin
                d_drop = 1'b1;
            end else begin
                unique case (ph)
                    PH_IDLE: begin
                        if (cell_eom) begin
                            d_push = 1'b1; d_inl = 1'b1;
                            d_err = !cell_crc_ok; d_len = CELL_O;
                        end else if (fq_nonempty[ep]) begin
                            d_pop = 1'b1; d_wr = 1'b1; d_idx = head; d_off = '0;
                            ctx_we = 1'b1; n_ph = PH_FILL; n_idx = head;
                            n_off = CELL_O; n_ovf = 1'b0;
                        end else begin
                            ctx_we = 1'b1; n_ph = PH_SKIP;
                        end
                    end
                    PH_FILL: begin
                        ctx_we = 1'b1;
                        if (fits) begin
                            d_wr = 1'b1; d_off = off; n_off = sum[OFF_W-1:0];
                        end else begin
                            n_ovf = 1'b1;
                        end
                        if (cell_eom) begin
                            d_push = 1'b1; d_len = n_off;
                            d_err = n_ovf || !cell_crc_ok; n_ph = PH_IDLE;
                        end
                    end
                    PH_SKIP: begin
                        if (cell_eom) begin
                            ctx_we = 1'b1; n_ph = PH_IDLE;
                        end
                    end
                    default: begin
                        ctx_we = 1'b1; n_ph = PH_IDLE;
                    end
                endcase
            end
        end
    end

    // Register the strobes and their fields toward the queues and buffers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fq_pop <= 1'b0; buf_wr <= 1'b0; rq_push <= 1'b0;
            rq_inline <= 1'b0; rq_err <= 1'b0;
            buf_off <= '0; rq_len <= '0; out_ep <= '0; out_idx <= '0;
            out_data <= '0;
        end else begin
            fq_pop <= d_pop; buf_wr <= d_wr; rq_push <= d_push;
            rq_inline <= d_inl; rq_err <= d_err;
            buf_off <= d_off; rq_len <= d_len; out_ep <= ep; out_idx <= d_idx;
            if (d_wr || d_push) out_data <= cell_data;
        end
    end

    // Count cells dropped for lack of a map entry.
    always_ff @(posedge clk) begin
        if (!rst_n)      drop_count <= '0;
        else if (d_drop) drop_count <= drop_count + 1'b1;
    end
endmodule

// File: rtl/cr_checks.sv
// Port-level checks on the reassembly engine, attached by bind below.
// Assumes: no cells are offered during reset.
module cr_checks #(
    parameter int BUF_BYTES = 65536,
    parameter int NUM_EP    = 4,
    parameter int EP_W      = 2,
    parameter int CNT_W     = 16,
    parameter int OFF_W     = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cell_valid,
    input logic [NUM_EP-1:0] fq_nonempty,
    input logic              fq_pop,
    input logic              buf_wr,
    input logic [OFF_W-1:0]  buf_off,
    input logic              rq_push,
    input logic              rq_inline,
    input logic [OFF_W-1:0]  rq_len,
    input logic [EP_W-1:0]   out_ep,
    input logic [CNT_W-1:0]  drop_count
);
    localparam logic [OFF_W:0] BUF_L  = (OFF_W+1)'(BUF_BYTES);
    localparam logic [OFF_W:0] CELL_L = (OFF_W+1)'(48);

    // A pop always comes with the first write at offset zero.
    assert_pop_starts_buffer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fq_pop |-> (buf_wr && buf_off == '0 && !rq_push));

    // An inline descriptor takes no buffer.
    assert_inline_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_push && rq_inline) |-> (!fq_pop && !buf_wr && {1'b0, rq_len} == CELL_L));

    // A drop produces no other strobe.
    assert_drop_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> !(fq_pop || buf_wr || rq_push));

    // No write runs past the end of the buffer.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> (({1'b0, buf_off} + CELL_L) <= BUF_L));

    // A pop only happens on a queue that was non-empty.
    assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fq_pop |-> ((($past(fq_nonempty) >> out_ep) & NUM_EP'(1)) != '0));

    // Descriptor length is non-zero and within the buffer.
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rq_push |-> (rq_len != '0 && {1'b0, rq_len} <= BUF_L));

    // No strobe without a cell in the cycle before.
    assert_quiet_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cell_valid) |-> !(fq_pop || buf_wr || rq_push));
endmodule

bind cell_reasm cr_checks #(
    .BUF_BYTES(BUF_BYTES), .NUM_EP(NUM_EP), .EP_W(EP_W), .CNT_W(CNT_W), .OFF_W(OFF_W)
) u_chk (.*);

// File: tb/tb_cell_reasm.sv
`timescale 1ns/1ps
module tb_cell_reasm;
    localparam int NVC = 16, NEP = 4, IW = 8, BUFB = 144, CW = 16;
    localparam int VW = 4, EW = 2, OW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic map_we = 0, map_valid = 0, cell_valid = 0, cell_eom = 0, cell_crc_ok = 0;
    logic [VW-1:0] map_vc = '0, cell_vc = '0;
    logic [EW-1:0] map_ep = '0;
    logic [383:0]  cell_data = '0;
    logic [NEP-1:0] fq_nonempty;
    logic [NEP*IW-1:0] fq_head;
    logic fq_pop, buf_wr, rq_push, rq_inline, rq_err;
    logic [OW-1:0] buf_off, rq_len;
    logic [EW-1:0] out_ep;
    logic [IW-1:0] out_idx;
    logic [383:0]  out_data;
    logic [CW-1:0] drop_count;

    cell_reasm #(.NUM_VC(NVC), .NUM_EP(NEP), .IDX_W(IW), .BUF_BYTES(BUFB), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_vc(map_vc), .map_valid(map_valid),
        .map_ep(map_ep), .cell_valid(cell_valid), .cell_vc(cell_vc), .cell_eom(cell_eom),
        .cell_crc_ok(cell_crc_ok), .cell_data(cell_data), .fq_nonempty(fq_nonempty),
        .fq_head(fq_head), .fq_pop(fq_pop), .buf_wr(buf_wr), .buf_off(buf_off),
        .rq_push(rq_push), .rq_inline(rq_inline), .rq_err(rq_err), .rq_len(rq_len),
        .out_ep(out_ep), .out_idx(out_idx), .out_data(out_data), .drop_count(drop_count)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit pop; bit wr; bit push; bit inl; bit err;
        int ep; int idx; int off; int len;
        logic [383:0] data; string req;
    } exp_t;
    exp_t sbq[$];

    int nvec = 0, nbad = 0, exp_drop = 0;
    bit done = 0;
    // Bench model of the requirements.
    int m_ph[NVC]; int m_idx[NVC]; int m_off[NVC]; bit m_ovf[NVC];
    bit t_vld[NVC]; int t_ep[NVC];
    int hd[NEP]; bit ne[NEP];

    always_comb begin
        for (int i = 0; i < NEP; i++) begin
            fq_nonempty[i] = ne[i];
            fq_head[i*IW +: IW] = IW'(hd[i]);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: compare each output event against the scoreboard.
    always @(posedge clk) begin
        #1;
        if (rst_n && (fq_pop || buf_wr || rq_push)) begin
            nvec++;
            if (sbq.size() == 0) begin
                nbad++;
                $display("FAIL unexpected output: actual pop=%0b wr=%0b push=%0b expected none",
                         fq_pop, buf_wr, rq_push);
            end else begin
                exp_t e;
                bit bad;
                e = sbq.pop_front();
                bad = 0;
                if ({fq_pop, buf_wr, rq_push} != {e.pop, e.wr, e.push}) begin
                    bad = 1;
                    $display("FAIL %s strobes: actual %b expected %b", e.req,
                             {fq_pop, buf_wr, rq_push}, {e.pop, e.wr, e.push});
                end
                if (int'(out_ep) != e.ep) begin
                    bad = 1;
                    $display("FAIL %s ep: actual %0d expected %0d", e.req, out_ep, e.ep);
                end
                if (e.wr && (int'(out_idx) != e.idx || int'(buf_off) != e.off || out_data != e.data)) begin
                    bad = 1;
                    $display("FAIL %s write: actual idx %0d off %0d expected idx %0d off %0d",
                             e.req, out_idx, buf_off, e.idx, e.off);
                end
                if (e.push && (rq_inline != e.inl || rq_err != e.err || int'(rq_len) != e.len)) begin
                    bad = 1;
                    $display("FAIL %s desc: actual inl %0b err %0b len %0d expected inl %0b err %0b len %0d",
                             e.req, rq_inline, rq_err, rq_len, e.inl, e.err, e.len);
                end
                if (e.push && e.inl && out_data != e.data) begin
                    bad = 1;
                    $display("FAIL %s inline data: actual %h expected %h", e.req, out_data[31:0], e.data[31:0]);
                end
                if (e.push && !e.inl && int'(out_idx) != e.idx) begin
                    bad = 1;
                    $display("FAIL %s desc idx: actual %0d expected %0d", e.req, out_idx, e.idx);
                end
                if (bad) nbad++;
            end
        end
    end

    task automatic map_set(input int vc, input bit v, input int ep);
        map_we = 1; map_vc = VW'(vc); map_valid = v; map_ep = EW'(ep);
        @(negedge clk);
        map_we = 0;
        t_vld[vc] = v; t_ep[vc] = ep;
    endtask

    // Driver: predict the result of one cell, queue it, drive the cell.
    task automatic send_cell(input int vc, input bit eom, input bit crc, input int seed, input string req);
        exp_t e;
        int ep;
        bit popped, dropped;
        logic [383:0] d;
        d = {12{32'(seed)}};
        e.pop = 0; e.wr = 0; e.push = 0; e.inl = 0; e.err = 0;
        e.ep = 0; e.idx = 0; e.off = 0; e.len = 0; e.data = d; e.req = req;
        popped = 0; dropped = 0; ep = 0;
        if (!t_vld[vc]) begin
            exp_drop++; dropped = 1;
        end else begin
            ep = t_ep[vc]; e.ep = ep;
            case (m_ph[vc])
                0: if (eom) begin
                       e.push = 1; e.inl = 1; e.err = !crc; e.len = 48;
                   end else if (ne[ep]) begin
                       e.pop = 1; e.wr = 1; e.idx = hd[ep]; e.off = 0;
                       m_ph[vc] = 1; m_idx[vc] = hd[ep]; m_off[vc] = 48; m_ovf[vc] = 0;
                       popped = 1;
                   end else m_ph[vc] = 2;
                1: begin
                       if (m_off[vc] + 48 <= BUFB) begin
                           e.wr = 1; e.idx = m_idx[vc]; e.off = m_off[vc]; m_off[vc] += 48;
                       end else m_ovf[vc] = 1;
                       if (eom) begin
                           e.push = 1; e.idx = m_idx[vc]; e.len = m_off[vc];
                           e.err = m_ovf[vc] || !crc; m_ph[vc] = 0;
                       end
                   end
                default: if (eom) m_ph[vc] = 0;
            endcase
        end
        if (e.pop || e.wr || e.push) sbq.push_back(e);
        cell_valid = 1; cell_vc = VW'(vc); cell_eom = eom; cell_crc_ok = crc; cell_data = d;
        @(negedge clk);
        cell_valid = 0; cell_eom = 0;
        if (popped) hd[ep] = (hd[ep] + 1) % 256;
        if (dropped) chk(int'(drop_count) == exp_drop, {req, " drop count"}, int'(drop_count), exp_drop);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NVC; i++) begin
            m_ph[i] = 0; m_idx[i] = 0; m_off[i] = 0; m_ovf[i] = 0; t_vld[i] = 0; t_ep[i] = 0;
        end
        for (int i = 0; i < NEP; i++) begin
            hd[i] = 16 * i + 3; ne[i] = 1;
        end
        ne[3] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R9: reset state
        chk({fq_pop, buf_wr, rq_push, rq_inline, rq_err} == 5'b0, "R9 strobes", 0, 0);
        chk(drop_count == '0, "R9 drop count", int'(drop_count), 0);
        // R1 / R9: map starts invalid, so this cell drops
        send_cell(3, 0, 1, 32'h11, "R1 unmapped");
        map_set(1, 1, 2);
        map_set(2, 1, 1);
        map_set(3, 1, 3);
        // R5: single-cell messages, good and bad CRC
        send_cell(1, 1, 1, 32'hA1, "R5 inline ok");
        send_cell(1, 1, 0, 32'hA2, "R5 inline crc err");
        // R2 R3 R4: three-cell message
        send_cell(1, 0, 1, 32'hB1, "R2 first cell");
        send_cell(1, 0, 1, 32'hB2, "R3 second cell");
        send_cell(1, 1, 1, 32'hB3, "R4 last cell");
        // R7: two channels interleaved cell by cell, bad CRC on channel 2
        send_cell(1, 0, 1, 32'hC1, "R7 vc1 first");
        send_cell(2, 0, 1, 32'hD1, "R7 vc2 first");
        send_cell(1, 1, 1, 32'hC2, "R7 vc1 last");
        send_cell(2, 0, 1, 32'hD2, "R7 vc2 middle");
        send_cell(2, 1, 0, 32'hD3, "R4 vc2 crc err");
        // R6: empty free queue, whole message discarded
        send_cell(3, 0, 1, 32'hE1, "R6 skip first");
        send_cell(3, 0, 1, 32'hE2, "R6 skip middle");
        send_cell(3, 1, 1, 32'hE3, "R6 skip last");
        repeat (2) @(negedge clk);
        chk(sbq.size() == 0, "R6 no output", sbq.size(), 0);
        ne[3] = 1;
        send_cell(3, 0, 1, 32'hE4, "R6 recover first");
        send_cell(3, 1, 1, 32'hE5, "R6 recover last");
        // R8: four cells into a three-cell buffer
        send_cell(1, 0, 1, 32'hF1, "R8 cell0");
        send_cell(1, 0, 1, 32'hF2, "R8 cell1");
        send_cell(1, 0, 1, 32'hF3, "R8 cell2");
        send_cell(1, 1, 1, 32'hF4, "R8 overflow last");
        // R10: map write and cell on the same channel in one cycle
        map_we = 1; map_vc = 4'd7; map_valid = 1; map_ep = 2'd0;
        send_cell(7, 1, 1, 32'h71, "R10 same cycle drop");
        map_we = 0; t_vld[7] = 1; t_ep[7] = 0;
        send_cell(7, 1, 1, 32'h72, "R10 after write");
        // R1: unmapping a channel makes its cells drop
        map_set(2, 0, 0);
        send_cell(2, 1, 1, 32'h99, "R1 unmapped again");
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R4 all descriptors seen", sbq.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule